// File: doc/BRIEF.md
# Quadrature Direction Discriminator Counter

This block turns the two phase-shifted signals of an incremental position transducer, channel A and channel B, into single-cycle step pulses. Those pulses move an up/down position counter. A three-bit mode input selects which transitions of A and B count. The choices give one, two or four counts per quadrature period. One further mode ignores the transducer and steps the counter from a pair of active-low cascade inputs.

A and B are sampled twice. The first sample is taken on the falling clock edge and the second on the following rising edge. The step decision is made from those four stored bits and the mode. When A and B both change inside one sample interval, the block counts nothing and raises an error pulse. Software can overwrite the counter one byte at a time. A wrap in either direction produces a one-cycle active-low strobe, which lets a wider count be built outside the block.

Top module: `quad_disc_counter`

## Requirements
- R1: A and B are captured on the falling clock edge and passed to a second stage on the next rising edge. A level that is stable before a falling edge is reflected in `up_o`/`dn_o`/`cnt_o` right after the rising edge that follows it.
- R2: Direction rule. A transition counts as forward when A leads B (state order AB = 00, 10, 11, 01) and as backward otherwise. A counted forward transition increments `cnt_o` by one, and a counted backward transition decrements it by one.
- R3: With `mode_i`=1, the counter counts up on A rising while B is low and counts down on A falling while B is low. No other transition counts.
- R4: With `mode_i`=2, the counter counts up on B rising while A is high and counts down on B falling while A is high. No other transition counts.
- R5: With `mode_i`=3, every transition of A counts. With `mode_i`=4, every transition of B counts. Direction follows R2 in both modes.
- R6: With `mode_i`=5, every single-channel transition of A or B counts, following R2.
- R7: In modes 1 to 5, a sample interval in which both A and B changed produces no count and a one-cycle high pulse on `err_o`.
- R8: With `mode_i`=0, A and B have no effect. The counter steps up by one in each clock where `casc_up_ni` is low and `casc_dn_ni` is high, and steps down by one in the reverse case. It does not step when both are low. With `mode_i`=6 or 7, nothing counts.
- R9: `carry_no` is low for exactly one cycle when an up step wraps the counter from all-ones to zero. `borrow_no` is low for exactly one cycle when a down step wraps it from zero to all-ones.
- R10: When `ld_en_i` is high, `ld_data_i` replaces byte `ld_sel_i` of the counter (byte 0 is bits 7:0). A load takes priority over any step in the same cycle, and that cycle gives no step pulse.
- R11: While `rst_ni` is low, `cnt_o` is zero, the four sampling flops are cleared, `up_o`, `dn_o` and `err_o` are low, and `carry_no` and `borrow_no` are high.
- R12: `up_o` and `dn_o` pulse high for one cycle for each step that is applied to the counter. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; both edges are used |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 1 | Quadrature channel A |
| b_i | input | 1 | Quadrature channel B |
| mode_i | input | 3 | Edge qualification mode |
| casc_up_ni | input | 1 | Active-low up request, used in mode 0 |
| casc_dn_ni | input | 1 | Active-low down request, used in mode 0 |
| ld_en_i | input | 1 | Byte preload strobe |
| ld_sel_i | input | SEL_W | Byte index for the preload |
| ld_data_i | input | 8 | Preload byte |
| cnt_o | output | CNT_W | Position count |
| up_o | output | 1 | One-cycle pulse for an applied up step |
| dn_o | output | 1 | One-cycle pulse for an applied down step |
| err_o | output | 1 | One-cycle pulse for an illegal double transition |
| carry_no | output | 1 | Active-low wrap strobe, all-ones to zero |
| borrow_no | output | 1 | Active-low wrap strobe, zero to all-ones |

## Verification
The bench uses the default CNT_W of 16, which gives two preload bytes and a one-bit byte select. Each byte can then be written on its own, and a two-byte preload places the counter next to either wrap point in a few cycles. For every one of the eight mode values, the bench drives all sixteen (previous, next) AB pairs from every state. This covers every legal quarter step in both directions and every illegal double step. An arithmetic model gives the expected count, pulses and strobes for each case.

// File: rtl/quad_pkg.sv
package quad_pkg;
  typedef enum logic [2:0] {
    MODE_EXT  = 3'd0,
    MODE_X1_A = 3'd1,
    MODE_X1_B = 3'd2,
    MODE_X2_A = 3'd3,
    MODE_X2_B = 3'd4,
    MODE_X4   = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } quad_mode_e;

  typedef struct packed {
    logic a;
    logic b;
  } ab_t;
endpackage

// File: rtl/quad_sampler.sv
module quad_sampler
  import quad_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output ab_t  cur_o,
  output ab_t  prev_o
);
  ab_t s1_q, s2_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else         s1_q <= '{a: a_i, b: b_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_q <= '0;
    else         s2_q <= s1_q;
  end

  assign cur_o  = s1_q;
  assign prev_o = s2_q;

  // R11
  rst_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> (s1_q == '0 && s2_q == '0));
endmodule

// File: rtl/quad_edge_qual.sv
module quad_edge_qual
  import quad_pkg::*;
(
  input  quad_mode_e mode_i,
  input  ab_t        cur_i,
  input  ab_t        prev_i,
  input  logic       casc_up_ni,
  input  logic       casc_dn_ni,
  output logic       inc_o,
  output logic       dec_o,
  output logic       err_o
);
  logic ch_a, ch_b, both, fwd_a, fwd_b, use_a, use_b;

  assign ch_a  = cur_i.a ^ prev_i.a;
  assign ch_b  = cur_i.b ^ prev_i.b;
  assign both  = ch_a & ch_b;
  // A edge is forward when new A differs from B; B edge when new B equals A
  assign fwd_a = cur_i.a ^ prev_i.b;
  assign fwd_b = ~(cur_i.b ^ prev_i.a);

  always_comb begin
    use_a = 1'b0;
    use_b = 1'b0;
    unique case (mode_i)
      MODE_X1_A: use_a = ch_a & ~prev_i.b;
      MODE_X1_B: use_b = ch_b &  prev_i.a;
      MODE_X2_A: use_a = ch_a;
      MODE_X2_B: use_b = ch_b;
      MODE_X4: begin
        use_a = ch_a;
        use_b = ch_b;
      end
      default: ;
    endcase
  end

  always_comb begin
    inc_o = 1'b0;
    dec_o = 1'b0;
    err_o = 1'b0;
    unique case (mode_i)
      MODE_EXT: begin
        inc_o = ~casc_up_ni &  casc_dn_ni;
        dec_o =  casc_up_ni & ~casc_dn_ni;
      end
      MODE_X1_A, MODE_X1_B, MODE_X2_A, MODE_X2_B, MODE_X4: begin
        err_o = both;
        if (!both) begin
          inc_o = (use_a & fwd_a)  | (use_b & fwd_b);
          dec_o = (use_a & ~fwd_a) | (use_b & ~fwd_b);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/quad_updown_cnt.sv
module quad_updown_cnt #(
  parameter int CNT_W  = 16,
  parameter int NBYTES = CNT_W / 8,
  parameter int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             ld_en_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic [7:0]       ld_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             dn_o,
  output logic             carry_no,
  output logic             borrow_no
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, ld_val;
  logic up_d, dn_d;

  always_comb begin
    ld_val = cnt_q;
    for (int i = 0; i < NBYTES; i++) begin
      if (ld_sel_i == SEL_W'(i)) ld_val[i*8 +: 8] = ld_data_i;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    up_d  = 1'b0;
    dn_d  = 1'b0;
    if (ld_en_i) begin
      cnt_d = ld_val;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
      up_d  = 1'b1;
    end else if (dec_i) begin
      cnt_d = cnt_q - 1'b1;
      dn_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      up_o      <= 1'b0;
      dn_o      <= 1'b0;
      carry_no  <= 1'b1;
      borrow_no <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      up_o      <= up_d;
      dn_o      <= dn_d;
      carry_no  <= ~(up_d & (cnt_q == ALL1));
      borrow_no <= ~(dn_d & (cnt_q == '0));
    end
  end

  assign cnt_o = cnt_q;

  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |-> cnt_q == $past(cnt_q) - 1'b1);
  // R12
  up_dn_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
  // R9
  carry_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no |-> (up_o && cnt_q == '0));
  // R9
  borrow_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !borrow_no |-> (dn_o && cnt_q == ALL1));
endmodule

// File: rtl/quad_disc_counter.sv
module quad_disc_counter
  import quad_pkg::*;
#(
  parameter int  CNT_W  = 16,
  localparam int NBYTES = CNT_W / 8,
  localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [2:0]       mode_i,
  input  logic             casc_up_ni,
  input  logic             casc_dn_ni,
  input  logic             ld_en_i,
  input  logic [SEL_W-1:0] ld_sel_i,
  input  logic [7:0]       ld_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             dn_o,
  output logic             err_o,
  output logic             carry_no,
  output logic             borrow_no
);
  ab_t  cur, prev;
  logic inc, dec, err;

  quad_sampler u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  quad_edge_qual u_qual (
    .mode_i     (quad_mode_e'(mode_i)),
    .cur_i      (cur),
    .prev_i     (prev),
    .casc_up_ni (casc_up_ni),
    .casc_dn_ni (casc_dn_ni),
    .inc_o      (inc),
    .dec_o      (dec),
    .err_o      (err)
  );

  quad_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .dec_i     (dec),
    .ld_en_i   (ld_en_i),
    .ld_sel_i  (ld_sel_i),
    .ld_data_i (ld_data_i),
    .cnt_o     (cnt_o),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .carry_no  (carry_no),
    .borrow_no (borrow_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= err;
  end

  // R7
  err_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !up_o && !dn_o);
endmodule

// File: tb/quad_disc_counter_bench.sv
module quad_disc_counter_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a = 1'b0, b = 1'b0;
  logic [2:0] mode = 3'd5;
  logic cup = 1'b1, cdn = 1'b1;
  logic ld_en = 1'b0;
  logic ld_sel = 1'b0;
  logic [7:0] ld_data = '0;
  logic [W-1:0] cnt;
  logic up, dn, err, carry_n, borrow_n;

  int total = 0;
  int bad = 0;
  logic [W-1:0] exp_cnt = '0;
  logic cur_a = 1'b0, cur_b = 1'b0;

  always #5 clk = ~clk;

  quad_disc_counter #(.CNT_W(W)) u_quad_disc_counter (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .mode_i(mode),
    .casc_up_ni(cup), .casc_dn_ni(cdn), .ld_en_i(ld_en), .ld_sel_i(ld_sel),
    .ld_data_i(ld_data), .cnt_o(cnt), .up_o(up), .dn_o(dn), .err_o(err),
    .carry_no(carry_n), .borrow_no(borrow_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R8";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // expected step from direction rule and mode table
  task automatic model(input logic [2:0] m, input logic pa, pb, na, nb, input logic cu, cd,
                       output logic eu, ed, ee);
    logic ca, cb, fa, fb, ua, ub;
    ca = pa ^ na; cb = pb ^ nb;
    fa = na ^ pb; fb = ~(nb ^ pa);
    eu = 0; ed = 0; ee = 0;
    ua = (m == 1 && ca && !pb) || ((m == 3 || m == 5) && ca);
    ub = (m == 2 && cb && pa)  || ((m == 4 || m == 5) && cb);
    if (m == 0) begin
      eu = !cu && cd; ed = cu && !cd;
    end else if (m <= 5) begin
      if (ca && cb) ee = 1;
      else begin
        eu = (ua && fa) || (ub && fb);
        ed = (ua && !fa) || (ub && !fb);
      end
    end
  endtask

  task automatic step(input logic na, nb, input logic cu, cd, input logic le, input logic ls,
                      input logic [7:0] ld, input string req);
    logic eu, ed, ee, ec, eb;
    @(posedge clk); #2;
    a = na; b = nb; cup = cu; cdn = cd; ld_en = le; ld_sel = ls; ld_data = ld;
    model(mode, cur_a, cur_b, na, nb, cu, cd, eu, ed, ee);
    cur_a = na; cur_b = nb;
    if (le) begin
      eu = 0; ed = 0;
      if (ls) exp_cnt[15:8] = ld; else exp_cnt[7:0] = ld;
    end
    ec = !(eu && exp_cnt == '1);
    eb = !(ed && exp_cnt == '0);
    if (eu) exp_cnt++;
    if (ed) exp_cnt--;
    @(posedge clk); #3;
    cup = 1'b1; cdn = 1'b1; ld_en = 1'b0;
    chk(req, "cnt", cnt, exp_cnt);
    chk(req, "up", up, eu);
    chk(req, "dn", dn, ed);
    chk("R7", "err", err, ee);
    chk("R9", "carry_n", carry_n, ec);
    chk("R9", "borrow_n", borrow_n, eb);
  endtask

  task automatic move(input logic na, nb);
    step(na, nb, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, tag(mode));
  endtask

  function automatic logic [1:0] fwd_next(input logic [1:0] s);
    case (s)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] bwd_next(input logic [1:0] s);
    case (s)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] s;
    #13;
    // R11
    chk("R11", "cnt in reset", cnt, 0);
    chk("R11", "up/dn/err in reset", {up, dn, err}, 0);
    chk("R11", "strobes in reset", {carry_n, borrow_n}, 2'b11);
    @(posedge clk); #2 rst_ni = 1'b1;
    @(posedge clk); #3;
    chk("R11", "cnt after reset", cnt, 0);

    // R1 R2 R3..R8: exhaustive transitions per mode
    for (int m = 0; m < 8; m++) begin
      @(posedge clk); #2 mode = 3'(m);
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          move(p[1], p[0]);
          move(n[1], n[0]);
        end
    end

    // R8 cascade inputs
    @(posedge clk); #2 mode = 3'd0;
    step(cur_a, cur_b, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R8");
    step(cur_a, cur_b, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
    step(cur_a, cur_b, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
    step(!cur_a, cur_b, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R8");

    // R10 preload, R9 wrap
    @(posedge clk); #2 mode = 3'd5;
    step(cur_a, cur_b, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, "R10");
    step(cur_a, cur_b, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, "R10");
    s = fwd_next({cur_a, cur_b});
    move(s[1], s[0]);
    chk("R9", "wrap to zero", cnt, 0);
    chk("R9", "carry low", carry_n, 0);
    @(posedge clk); #3;
    chk("R9", "carry one cycle", carry_n, 1);
    chk("R12", "up one cycle", up, 0);
    s = bwd_next({cur_a, cur_b});
    move(s[1], s[0]);
    chk("R9", "borrow low", borrow_n, 0);
    // R10 load beats a step in the same cycle
    s = fwd_next({cur_a, cur_b});
    step(s[1], s[0], 1'b1, 1'b1, 1'b1, 1'b1, 8'h12, "R10");
    chk("R10", "load priority", cnt, 16'h12FF);
    step(cur_a, cur_b, 1'b1, 1'b1, 1'b1, 1'b0, 8'h34, "R10");

    // R6 sustained x4 forward then back
    for (int i = 0; i < 8; i++) begin
      s = fwd_next({cur_a, cur_b});
      move(s[1], s[0]);
    end
    chk("R6", "x4 forward run", cnt, 16'h123C);
    for (int i = 0; i < 3; i++) begin
      s = bwd_next({cur_a, cur_b});
      move(s[1], s[0]);
    end
    chk("R2", "x4 backward run", cnt, 16'h1239);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule